// File: doc/BRIEF.md
# Memory-Side Atomic Read-Modify-Write Unit

This block sits in front of a small word-addressed store of 64-bit words. It turns ordinary loads and stores into indivisible read-modify-write operations. The operation is picked by the top three bits of the request address, so a client needs no extra command wires: a load whose upper bits carry a code returns the word's old value and updates the word, and a store whose upper bits carry a code merges its data into the word. Counters, ticket locks and flag words can then be built with one request per operation.

Each request passes through two register stages. The first stage captures the request and reads the target word and the word after it. The second stage computes the new value, writes it back and registers the load response. A request may follow the previous one on the next cycle. When a request reads a word that the stage ahead is writing in that same cycle, it takes the new value from that stage, so every operation sees the results of all earlier ones.

Top module: `atom_rmw_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first load completes, `resp_valid` is low. Asserting reset cancels a response that is still pending.
- R2: Address bits [31:29] carry the operation code and bits [5:0] the word index. The bits between them are ignored. Code 0 with `req_write`=0 returns the word unchanged, and code 0 with `req_write`=1 overwrites the word with `req_wdata`.
- R3: Load code 1 (clear) returns the old word and leaves zero in it.
- R4: Load code 2 (increment) and load code 3 (decrement) return the old word and leave it plus or minus one, wrapping modulo 2^64.
- R5: Load codes 4 (bounded increment) and 5 (bounded decrement) compare the word with a bound held at index+1 (modulo 64). If they differ, the load returns the old word and steps the word by +1 or -1. If they are equal, the load returns 0x8000_0000_0000_0000 and leaves memory unchanged.
- R6: Store code 1 adds `req_wdata` to the word (wrapping), store code 2 ORs it in and store code 3 XORs it in.
- R7: Store code 4 keeps the unsigned maximum of the word and `req_wdata`, and store code 5 keeps the two's-complement signed maximum.
- R8: A load accepted on clock edge k gives `resp_valid` high for exactly the cycle after edge k+1, with its data on `resp_rdata`. A store never raises `resp_valid`.
- R9: Requests on consecutive cycles see each other's results, both on the target word and on the bound word.
- R10: Codes 6 and 7 behave as code 0 for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for store-type, 0 for load-type |
| req_addr | input | 32 | Operation code in [31:29], word index in [5:0] |
| req_wdata | input | 64 | Store data or merge operand |
| resp_valid | output | 1 | Load response present |
| resp_rdata | output | 64 | Old word value, or the failure marker for a refused bounded step |

## Verification
A wrong word value stays hidden until a later load reads it, so the stimulus follows every update with a load of the same word. A corrupted result then appears in the very next response, two cycles after that load. A broken forwarding path shows up only when requests arrive back to back, so a dedicated burst issues increment, merge and bound-word writes on consecutive cycles and compares each response on the cycle it arrives. A wrong bound comparison shows either as a missing marker or as a counter that has moved past its bound, and both are checked at the ports, including the bound that wraps to index 0.

// File: rtl/atom_pkg.sv
`timescale 1ns/1ps
package atom_pkg;

  // Operation codes carried in the top three address bits
  localparam logic [2:0] OPC_PLAIN = 3'd0;
  localparam logic [2:0] OPC_1     = 3'd1;
  localparam logic [2:0] OPC_2     = 3'd2;
  localparam logic [2:0] OPC_3     = 3'd3;
  localparam logic [2:0] OPC_4     = 3'd4;
  localparam logic [2:0] OPC_5     = 3'd5;

  // Internal action selected from direction and code
  typedef enum logic [3:0] {
    ACT_RD   = 4'd0,
    ACT_WR   = 4'd1,
    ACT_CLR  = 4'd2,
    ACT_INC  = 4'd3,
    ACT_DEC  = 4'd4,
    ACT_BINC = 4'd5,
    ACT_BDEC = 4'd6,
    ACT_ADD  = 4'd7,
    ACT_OR   = 4'd8,
    ACT_XOR  = 4'd9,
    ACT_UMAX = 4'd10,
    ACT_SMAX = 4'd11
  } act_e;

endpackage

// File: rtl/atom_decode.sv
`timescale 1ns/1ps
module atom_decode
  import atom_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output act_e              act,
  output logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  idx_bnd
);

  localparam int OP_LSB = ADDR_W - 3;

  logic [2:0] opc;
  logic       unused_mid;

  assign opc        = addr[ADDR_W-1:OP_LSB];
  assign idx        = addr[IDX_W-1:0];
  assign idx_bnd    = idx + {{(IDX_W-1){1'b0}}, 1'b1};
  assign unused_mid = ^addr[OP_LSB-1:IDX_W];

  always_comb begin
    act = is_write ? ACT_WR : ACT_RD;
    if (!is_write) begin
      case (opc)
        OPC_1:   act = ACT_CLR;
        OPC_2:   act = ACT_INC;
        OPC_3:   act = ACT_DEC;
        OPC_4:   act = ACT_BINC;
        OPC_5:   act = ACT_BDEC;
        default: act = ACT_RD;
      endcase
    end else begin
      case (opc)
        OPC_1:   act = ACT_ADD;
        OPC_2:   act = ACT_OR;
        OPC_3:   act = ACT_XOR;
        OPC_4:   act = ACT_UMAX;
        OPC_5:   act = ACT_SMAX;
        default: act = ACT_WR;
      endcase
    end
  end

endmodule

// File: rtl/atom_alu.sv
`timescale 1ns/1ps
module atom_alu
  import atom_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  act_e              act,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] bnd,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] nxt,
  output logic              wr_en,
  output logic [DATA_W-1:0] rsp
);

  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] MARK = {1'b1, {(DATA_W-1){1'b0}}};

  logic at_bound;
  assign at_bound = (cur == bnd);

  always_comb begin
    nxt   = cur;
    wr_en = 1'b0;
    rsp   = cur;
    case (act)
      ACT_RD: ;
      ACT_WR:   begin nxt = opnd;       wr_en = 1'b1; end
      ACT_CLR:  begin nxt = '0;         wr_en = 1'b1; end
      ACT_INC:  begin nxt = cur + ONE;  wr_en = 1'b1; end
      ACT_DEC:  begin nxt = cur - ONE;  wr_en = 1'b1; end
      ACT_BINC: begin
        if (at_bound) rsp = MARK;
        else begin nxt = cur + ONE; wr_en = 1'b1; end
      end
      ACT_BDEC: begin
        if (at_bound) rsp = MARK;
        else begin nxt = cur - ONE; wr_en = 1'b1; end
      end
      ACT_ADD:  begin nxt = cur + opnd; wr_en = 1'b1; end
      ACT_OR:   begin nxt = cur | opnd; wr_en = 1'b1; end
      ACT_XOR:  begin nxt = cur ^ opnd; wr_en = 1'b1; end
      ACT_UMAX: begin
        nxt   = (opnd > cur) ? opnd : cur;
        wr_en = 1'b1;
      end
      ACT_SMAX: begin
        nxt   = ($signed(opnd) > $signed(cur)) ? opnd : cur;
        wr_en = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/atom_wordmem.sv
`timescale 1ns/1ps
module atom_wordmem #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][IDX_W-1:0]  raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem_q[raddr[g]];
  end

endmodule

// File: rtl/atom_rmw_unit.sv
`timescale 1ns/1ps
module atom_rmw_unit
  import atom_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata
);

  localparam int IDX_W = $clog2(DEPTH);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Request decode
  act_e             dec_act;
  logic [IDX_W-1:0] dec_idx;
  logic [IDX_W-1:0] dec_idx_bnd;

  atom_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
    .is_write (req_write),
    .addr     (req_addr),
    .act      (dec_act),
    .idx      (dec_idx),
    .idx_bnd  (dec_idx_bnd)
  );

  // Storage
  logic                       wb_en;
  logic [IDX_W-1:0]           wb_idx;
  logic [DATA_W-1:0]          wb_data;
  logic [1:0][IDX_W-1:0]      rd_idx;
  logic [1:0][DATA_W-1:0]     rd_data;

  assign rd_idx[0] = dec_idx;
  assign rd_idx[1] = dec_idx_bnd;

  atom_wordmem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NRD(2)) mem_i (
    .clk   (clk),
    .we    (wb_en),
    .waddr (wb_idx),
    .wdata (wb_data),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  // Forwarding from the write-back stage into the read stage
  logic [DATA_W-1:0] cur_fwd;
  logic [DATA_W-1:0] bnd_fwd;

  always_comb begin
    cur_fwd = rd_data[0];
    bnd_fwd = rd_data[1];
    if (wb_en && (wb_idx == dec_idx))     cur_fwd = wb_data;
    if (wb_en && (wb_idx == dec_idx_bnd)) bnd_fwd = wb_data;
  end

  // Stage A: captured request and operand words
  logic              a_vld_q, a_vld_d;
  logic              a_wr_q,  a_wr_d;
  act_e              a_act_q, a_act_d;
  logic [IDX_W-1:0]  a_idx_q, a_idx_d;
  logic [DATA_W-1:0] a_opd_q, a_opd_d;
  logic [DATA_W-1:0] a_cur_q, a_cur_d;
  logic [DATA_W-1:0] a_bnd_q, a_bnd_d;

  always_comb begin
    a_vld_d = req_valid;
    a_wr_d  = a_wr_q;
    a_act_d = a_act_q;
    a_idx_d = a_idx_q;
    a_opd_d = a_opd_q;
    a_cur_d = a_cur_q;
    a_bnd_d = a_bnd_q;
    if (req_valid) begin
      a_wr_d  = req_write;
      a_act_d = dec_act;
      a_idx_d = dec_idx;
      a_opd_d = req_wdata;
      a_cur_d = cur_fwd;
      a_bnd_d = bnd_fwd;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) a_vld_q <= 1'b0;
    else             a_vld_q <= a_vld_d;
  end

  always_ff @(posedge clk) begin
    a_wr_q  <= a_wr_d;
    a_act_q <= a_act_d;
    a_idx_q <= a_idx_d;
    a_opd_q <= a_opd_d;
    a_cur_q <= a_cur_d;
    a_bnd_q <= a_bnd_d;
  end

  // Stage B: modify and write back
  logic [DATA_W-1:0] alu_nxt;
  logic              alu_wr;
  logic [DATA_W-1:0] alu_rsp;

  atom_alu #(.DATA_W(DATA_W)) alu_i (
    .act   (a_act_q),
    .cur   (a_cur_q),
    .bnd   (a_bnd_q),
    .opnd  (a_opd_q),
    .nxt   (alu_nxt),
    .wr_en (alu_wr),
    .rsp   (alu_rsp)
  );

  assign wb_en   = a_vld_q && alu_wr;
  assign wb_idx  = a_idx_q;
  assign wb_data = alu_nxt;

  // Response registers
  logic              rsp_vld_q, rsp_vld_d;
  logic [DATA_W-1:0] rsp_dat_q, rsp_dat_d;

  always_comb begin
    rsp_vld_d = a_vld_q && !a_wr_q;
    rsp_dat_d = rsp_dat_q;
    if (a_vld_q && !a_wr_q) rsp_dat_d = alu_rsp;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rsp_vld_q <= 1'b0;
    else             rsp_vld_q <= rsp_vld_d;
  end

  always_ff @(posedge clk) begin
    rsp_dat_q <= rsp_dat_d;
  end

  assign resp_valid = rsp_vld_q;
  assign resp_rdata = rsp_dat_q;

endmodule

// File: rtl/atom_rmw_chk.sv
`timescale 1ns/1ps
module atom_rmw_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_rdata
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [1:0]       age_q;
  logic             armed;
  logic             ld_now;
  logic [2:0]       opc_now;
  logic [IDX_W-1:0] idx_now;
  logic             unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign armed       = (age_q == 2'd3);
  assign ld_now      = req_valid && !req_write;
  assign opc_now     = req_addr[ADDR_W-1 -: 3];
  assign idx_now     = req_addr[IDX_W-1:0];
  assign unused_bits = ^req_addr[ADDR_W-4:IDX_W];

  AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    ld_now |-> ##2 resp_valid);  // R8

  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> ##2 !resp_valid);  // R8

  AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && resp_valid) |-> $past(ld_now, 2));  // R8

  AST_CLEAR_THEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ld_now && opc_now == 3'd0 &&
     $past(ld_now && opc_now == 3'd1) && idx_now == $past(idx_now))
    |-> ##2 (resp_rdata == '0));  // R3

  AST_INC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ld_now && opc_now == 3'd0 &&
     $past(ld_now && opc_now == 3'd2) && idx_now == $past(idx_now))
    |-> ##2 (resp_rdata == $past(resp_rdata) + ONE));  // R9

endmodule

bind atom_rmw_unit atom_rmw_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .resp_valid (resp_valid),
  .resp_rdata (resp_rdata)
);

// File: tb/atom_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module atom_rmw_unit_tb_top;

  localparam logic [63:0] MARK = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MF0  = 64'hFFFF_FFFF_FFFF_FFF0;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        resp_valid;
  logic [63:0] resp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  atom_rmw_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [2:0]  opc;
    logic [5:0]  idx;
    logic [63:0] data;
    logic        chk;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 6'd3, 64'd10,   1'b0, 64'd0,   4'd2},
    '{1'b0, 3'd0, 6'd3, 64'd0,    1'b1, 64'd10,  4'd2},   // R2 plain read
    '{1'b0, 3'd2, 6'd3, 64'd0,    1'b1, 64'd10,  4'd4},   // R4 increment
    '{1'b0, 3'd3, 6'd3, 64'd0,    1'b1, 64'd11,  4'd4},   // R4 decrement
    '{1'b0, 3'd0, 6'd3, 64'd0,    1'b1, 64'd10,  4'd4},
    '{1'b0, 3'd1, 6'd3, 64'd0,    1'b1, 64'd10,  4'd3},   // R3 clear
    '{1'b0, 3'd0, 6'd3, 64'd0,    1'b1, 64'd0,   4'd3},
    '{1'b0, 3'd3, 6'd3, 64'd0,    1'b1, 64'd0,   4'd4},   // R4 wrap
    '{1'b0, 3'd0, 6'd3, 64'd0,    1'b1, ONES,    4'd4},
    '{1'b1, 3'd0, 6'd5, 64'd7,    1'b0, 64'd0,   4'd5},
    '{1'b1, 3'd0, 6'd6, 64'd8,    1'b0, 64'd0,   4'd5},
    '{1'b0, 3'd4, 6'd5, 64'd0,    1'b1, 64'd7,   4'd5},   // R5 step
    '{1'b0, 3'd4, 6'd5, 64'd0,    1'b1, MARK,    4'd5},   // R5 refused
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'd8,   4'd5},
    '{1'b0, 3'd5, 6'd5, 64'd0,    1'b1, MARK,    4'd5},
    '{1'b1, 3'd0, 6'd6, 64'd2,    1'b0, 64'd0,   4'd5},
    '{1'b0, 3'd5, 6'd5, 64'd0,    1'b1, 64'd8,   4'd5},
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'd7,   4'd5},
    '{1'b1, 3'd1, 6'd5, 64'd5,    1'b0, 64'd0,   4'd6},   // R6 add
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'd12,  4'd6},
    '{1'b1, 3'd2, 6'd5, 64'h30,   1'b0, 64'd0,   4'd6},   // R6 or
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'h3C,  4'd6},
    '{1'b1, 3'd3, 6'd5, 64'h0F,   1'b0, 64'd0,   4'd6},   // R6 xor
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'h33,  4'd6},
    '{1'b1, 3'd4, 6'd5, 64'h20,   1'b0, 64'd0,   4'd7},   // R7 umax keep
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'h33,  4'd7},
    '{1'b1, 3'd4, 6'd5, MF0,      1'b0, 64'd0,   4'd7},   // R7 umax take
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, MF0,     4'd7},
    '{1'b1, 3'd5, 6'd5, 64'd5,    1'b0, 64'd0,   4'd7},   // R7 smax take
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'd5,   4'd7},
    '{1'b1, 3'd5, 6'd5, ONES,     1'b0, 64'd0,   4'd7},   // R7 smax keep
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'd5,   4'd7},
    '{1'b1, 3'd1, 6'd5, ONES,     1'b0, 64'd0,   4'd6},   // R6 add wrap
    '{1'b0, 3'd0, 6'd5, 64'd0,    1'b1, 64'd4,   4'd6},
    '{1'b1, 3'd6, 6'd7, 64'h55,   1'b0, 64'd0,   4'd10},  // R10 code 6 store
    '{1'b0, 3'd7, 6'd7, 64'd0,    1'b1, 64'h55,  4'd10},  // R10 code 7 load
    '{1'b0, 3'd6, 6'd7, 64'd0,    1'b1, 64'h55,  4'd10}
  };

  function automatic logic [31:0] mk_addr(input logic [2:0] opc, input logic [5:0] idx,
                                          input logic [22:0] mid);
    return {opc, mid, idx};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
    end
  endtask

  // One isolated request; returns the response slot seen two edges later
  task automatic do_req(input logic wr, input logic [31:0] addr, input logic [63:0] data,
                        output logic v, output logic [63:0] rd, output logic early);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = data;
    @(negedge clk);
    early     = resp_valid;
    req_valid = 1'b0;
    @(negedge clk);
    v  = resp_valid;
    rd = resp_rdata;
  endtask

  // One request slot in a back-to-back burst
  task automatic push(input logic vld, input logic wr, input logic [31:0] addr,
                      input logic [63:0] data);
    req_valid = vld;
    req_write = wr;
    req_addr  = addr;
    req_wdata = data;
    @(negedge clk);
  endtask

  task automatic rd_word(input logic [5:0] idx, input logic [63:0] exp, input string tag);
    logic v, e;
    logic [63:0] d;
    do_req(1'b0, mk_addr(3'd0, idx, 23'd0), 64'd0, v, d, e);
    check(tag, {63'd0, v}, 64'd1);
    check(tag, d, exp);
  endtask

  task automatic wr_word(input logic [5:0] idx, input logic [63:0] val);
    logic v, e;
    logic [63:0] d;
    do_req(1'b1, mk_addr(3'd0, idx, 23'd0), val, v, d, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic v, e;
    logic [63:0] d;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 resp_valid in reset", {63'd0, resp_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 resp_valid after release", {63'd0, resp_valid}, 64'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i].wr, mk_addr(VECS[i].opc, VECS[i].idx, 23'd0), VECS[i].data, v, d, e);
      check($sformatf("R8 early slot vec %0d", i), {63'd0, e}, 64'd0);
      check($sformatf("R8 response flag vec %0d", i), {63'd0, v}, {63'd0, !VECS[i].wr});
      if (VECS[i].chk)
        check($sformatf("R%0d vec %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R2: middle address bits are ignored
    do_req(1'b1, mk_addr(3'd0, 6'd12, 23'h55_5555), 64'hABCD, v, d, e);
    rd_word(6'd12, 64'hABCD, "R2 middle bits ignored on store");
    do_req(1'b0, mk_addr(3'd2, 6'd12, 23'h2A_AAAA), 64'd0, v, d, e);
    check("R2 middle bits ignored on load", d, 64'hABCD);
    rd_word(6'd12, 64'hABCE, "R2 increment reached same word");

    // R5: bound word wraps to index 0
    wr_word(6'd0, 64'd3);
    wr_word(6'd63, 64'd3);
    do_req(1'b0, mk_addr(3'd4, 6'd63, 23'd0), 64'd0, v, d, e);
    check("R5 wrapped bound refuses", d, MARK);
    rd_word(6'd63, 64'd3, "R5 refused leaves word");
    wr_word(6'd0, 64'd9);
    do_req(1'b0, mk_addr(3'd4, 6'd63, 23'd0), 64'd0, v, d, e);
    check("R5 wrapped bound steps", d, 64'd3);
    rd_word(6'd63, 64'd4, "R5 stepped word");

    // R9: back-to-back burst
    wr_word(6'd9, 64'd100);
    push(1'b1, 1'b0, mk_addr(3'd2, 6'd9, 23'd0), 64'd0);
    push(1'b1, 1'b0, mk_addr(3'd2, 6'd9, 23'd0), 64'd0);
    check("R9 first inc", resp_rdata, 64'd100);
    push(1'b1, 1'b0, mk_addr(3'd0, 6'd9, 23'd0), 64'd0);
    check("R9 second inc sees first", resp_rdata, 64'd101);
    push(1'b1, 1'b1, mk_addr(3'd1, 6'd9, 23'd0), 64'd10);
    check("R9 read sees second inc", resp_rdata, 64'd102);
    push(1'b1, 1'b0, mk_addr(3'd0, 6'd9, 23'd0), 64'd0);
    check("R8 store in burst silent", {63'd0, resp_valid}, 64'd0);
    push(1'b1, 1'b1, mk_addr(3'd0, 6'd10, 23'd0), 64'd112);
    check("R9 read sees add", resp_rdata, 64'd112);
    push(1'b1, 1'b0, mk_addr(3'd4, 6'd9, 23'd0), 64'd0);
    check("R8 store in burst silent", {63'd0, resp_valid}, 64'd0);
    push(1'b0, 1'b0, 32'd0, 64'd0);
    check("R9 bound written just before", resp_rdata, MARK);
    push(1'b0, 1'b0, 32'd0, 64'd0);
    rd_word(6'd9, 64'd112, "R9 refused step left word");
    rd_word(6'd10, 64'd112, "R9 bound word");

    // R1: reset cancels a pending response
    push(1'b1, 1'b0, mk_addr(3'd0, 6'd9, 23'd0), 64'd0);
    req_valid = 1'b0;
    rst_n     = 1'b0;
    @(negedge clk);
    check("R1 pending response dropped", {63'd0, resp_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 quiet after second reset", {63'd0, resp_valid}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule